// File: doc/BRIEF.md
# Storage-Attribute Access Controller

This block sits between a load/store pipeline and a data cache plus its external bus port. It looks at each memory operation, resolves a four-bit storage attribute and decides which cache and bus actions the operation needs. The attribute holds write-through (bit 3), cache-inhibit (bit 2), coherence-required (bit 1) and guarded (bit 0). The possible actions are to serve it from the cache alone, to write the cache and the bus together, to fill a line (after copying back a dirty victim), or to go straight to external memory. When address translation is off, the supplied attribute is replaced by a fixed default.

Stores to cache-inhibited memory are gathered in a one-doubleword merge register, so several narrow stores can leave as one bus write. A full barrier always drains that register. A lighter ordering barrier drains it only when the buffered target is guarded. A non-matching access, a load, or an idle timeout also drains it. All bus traffic goes out in program order over one valid/ready channel. The requester is held, with `req_ready` low, until its operation is finished.

Top module: `cache_attr_ctrl`

## Requirements
- R1: When `req_xlate` is 0, the attribute used for the operation (and driven on `bus_attr`) is 4'b0011, whatever `req_wimg` holds.
- R2: A store with write-through set (bit 3) and cache-inhibit clear that hits pulses `cache_upd` and sends one `bus_op` = 1 (write) of the request's address, data and byte enables. It completes in the cycle that write is accepted.
- R3: A cacheable store without write-through that hits, and a cacheable load that hits, complete with no bus request. The store pulses `cache_upd`.
- R4: A cacheable miss that is not a write-through store first issues a copy-back (`bus_op` = 3, at `victim_addr`) if `cache_dirty` is set. It then issues a line fill (`bus_op` = 2, at the line-aligned request address). `cache_alloc` pulses when the fill is accepted, and a store also pulses `cache_upd` then.
- R5: A write-through store that misses issues only its single write. It raises neither `cache_alloc` nor `cache_upd`.
- R6: A cache-inhibited (bit 2) load issues a single read (`bus_op` = 0) at the request address. No cache-inhibited operation ever raises `cache_upd` or `cache_alloc`.
- R7: A cache-inhibited operation that finds `cache_hit` set pulses `attr_err` as it completes, and is still carried out on the bus.
- R8: Cache-inhibited stores to the same aligned doubleword with identical attributes merge into one buffer without bus traffic. When the buffer drains, it gives one write at the doubleword address whose byte enables are the union and whose bytes are the newest written.
- R9: Write-through stores are never merged: every one produces its own bus write, even to the same doubleword.
- R10: A full barrier (`req_op` = 2) drains a pending merge buffer. An ordering barrier (`req_op` = 3) drains it only if the buffered attribute has the guarded bit set, and otherwise completes with no bus traffic.
- R11: The merge buffer drains before any load or non-matching store proceeds, and on its own after TMO idle cycles.
- R12: After reset no bus request or cache command is active. A bus request keeps its address, opcode and byte enables until `bus_ready`, and `req_ready` is never high without `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Operation presented |
| req_ready | output | 1 | Operation completes this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 full barrier, 3 ordering barrier |
| req_addr | input | AW | Byte address |
| req_data | input | DW | Store data |
| req_be | input | DW/8 | Byte enables |
| req_wimg | input | 4 | Attribute: write-through, inhibit, coherent, guarded |
| req_xlate | input | 1 | Translation enabled for this access |
| cache_hit | input | 1 | Lookup hit for the request address |
| cache_dirty | input | 1 | Victim line is dirty |
| victim_addr | input | AW | Line address of the victim |
| cache_upd | output | 1 | Write the store into the cache |
| cache_alloc | output | 1 | Allocate the filled line |
| attr_err | output | 1 | Inhibited access found in cache |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus request accepted |
| bus_op | output | 2 | 0 read, 1 write, 2 fill, 3 copy-back |
| bus_addr | output | AW | Bus address |
| bus_data | output | DW | Write data |
| bus_be | output | DW/8 | Byte enables |
| bus_attr | output | 4 | Resolved attribute of the transfer |

## Verification
The properties assume the requester keeps `req_op`, address, data, attribute and the cache status inputs steady from the cycle `req_valid` rises until `req_ready`. The assertions compute the resolved attribute from those held inputs. The stimulus only changes request fields after a completing edge, and the bus responder raises `bus_ready` only while `bus_valid` is high. `cache_hit` is driven only as the lookup for the presented address. The merge tests keep inhibited stores free of hits, except where the error flag is under test.

// File: rtl/cattr_pkg.sv
package cattr_pkg;

    typedef enum logic [1:0] {
        REQ_LOAD  = 2'd0,
        REQ_STORE = 2'd1,
        REQ_SYNC  = 2'd2,
        REQ_ORDER = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        BUS_READ     = 2'd0,
        BUS_WRITE    = 2'd1,
        BUS_FILL     = 2'd2,
        BUS_COPYBACK = 2'd3
    } bus_op_e;

    typedef struct packed {
        logic wt;   // write-through
        logic ci;   // cache inhibited
        logic coh;  // coherence required
        logic grd;  // guarded
    } attr_t;

    localparam logic [3:0] ATTR_UNTRANSLATED = 4'b0011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_SINGLE,
        ST_COPYBACK,
        ST_FILL
    } ctl_state_e;

endpackage

// File: rtl/cattr_resolve.sv
module cattr_resolve
    import cattr_pkg::*;
(
    input  logic       xlate_on,
    input  logic [3:0] wimg_in,
    output attr_t      attr
);
    always_comb begin
        attr = xlate_on ? attr_t'(wimg_in) : attr_t'(ATTR_UNTRANSLATED);
    end
endmodule

// File: rtl/cattr_mergebuf.sv
module cattr_mergebuf
    import cattr_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 64,
    parameter int TMO = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    clr,
    input  logic                    idle_tick,
    input  logic [AW-$clog2(DW/8)-1:0] in_dword,
    input  logic [DW-1:0]           in_data,
    input  logic [DW/8-1:0]         in_be,
    input  attr_t                   in_attr,
    output logic                    vld,
    output logic [AW-$clog2(DW/8)-1:0] out_dword,
    output logic [DW-1:0]           out_data,
    output logic [DW/8-1:0]         out_be,
    output attr_t                   out_attr,
    output logic                    match,
    output logic                    expired
);
    localparam int BE = DW / 8;
    localparam int OFS = $clog2(BE);
    localparam int TW = $clog2(TMO + 1);

    typedef struct packed {
        logic              vld;
        logic [AW-OFS-1:0] dword;
        logic [DW-1:0]     data;
        logic [BE-1:0]     be;
        attr_t             attr;
        logic [TW-1:0]     cnt;
    } mb_s;

    mb_s mb_q, mb_d;

    always_comb begin
        mb_d    = mb_q;
        match   = mb_q.vld && (mb_q.dword == in_dword) && (mb_q.attr == in_attr);
        expired = mb_q.vld && (mb_q.cnt == TW'(TMO - 1));
        if (clr) begin
            mb_d.vld = 1'b0;
            mb_d.be  = '0;
            mb_d.cnt = '0;
        end else if (wr_en) begin
            for (int b = 0; b < BE; b++) begin
                if (in_be[b]) begin
                    mb_d.data[8*b +: 8] = in_data[8*b +: 8];
                end
            end
            mb_d.be    = (mb_q.vld ? mb_q.be : '0) | in_be;
            mb_d.vld   = 1'b1;
            mb_d.dword = in_dword;
            mb_d.attr  = in_attr;
            mb_d.cnt   = '0;
        end else if (idle_tick && mb_q.vld && !expired) begin
            mb_d.cnt = mb_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mb_q <= '0;
        end else begin
            mb_q <= mb_d;
        end
    end

    assign vld       = mb_q.vld;
    assign out_dword = mb_q.dword;
    assign out_data  = mb_q.data;
    assign out_be    = mb_q.be;
    assign out_attr  = mb_q.attr;
endmodule

// File: rtl/cache_attr_ctrl.sv
module cache_attr_ctrl
    import cattr_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 64,
    parameter int LINE_BYTES = 32,
    parameter int TMO        = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_op,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_data,
    input  logic [DW/8-1:0] req_be,
    input  logic [3:0]      req_wimg,
    input  logic            req_xlate,
    input  logic            cache_hit,
    input  logic            cache_dirty,
    input  logic [AW-1:0]   victim_addr,
    output logic            cache_upd,
    output logic            cache_alloc,
    output logic            attr_err,
    output logic            bus_valid,
    input  logic            bus_ready,
    output logic [1:0]      bus_op,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_data,
    output logic [DW/8-1:0] bus_be,
    output logic [3:0]      bus_attr
);
    localparam int BE   = DW / 8;
    localparam int OFS  = $clog2(BE);
    localparam int LOFS = $clog2(LINE_BYTES);

    typedef struct packed {
        ctl_state_e state;
    } ctl_s;

    ctl_s    ctl_q, ctl_d;
    attr_t   eff;
    req_op_e op;
    bus_op_e bop;
    logic    is_store;

    logic              mb_wr, mb_clr, idle_tick;
    logic              mb_vld, mb_match, mb_expired;
    logic [AW-OFS-1:0] mb_dword;
    logic [DW-1:0]     mb_data;
    logic [BE-1:0]     mb_be;
    attr_t             mb_attr;

    cattr_resolve i_resolve (
        .xlate_on (req_xlate),
        .wimg_in  (req_wimg),
        .attr     (eff)
    );

    cattr_mergebuf #(.AW(AW), .DW(DW), .TMO(TMO)) i_mergebuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mb_wr),
        .clr       (mb_clr),
        .idle_tick (idle_tick),
        .in_dword  (req_addr[AW-1:OFS]),
        .in_data   (req_data),
        .in_be     (req_be),
        .in_attr   (eff),
        .vld       (mb_vld),
        .out_dword (mb_dword),
        .out_data  (mb_data),
        .out_be    (mb_be),
        .out_attr  (mb_attr),
        .match     (mb_match),
        .expired   (mb_expired)
    );

    assign op       = req_op_e'(req_op);
    assign is_store = (op == REQ_STORE);

    always_comb begin
        ctl_d       = ctl_q;
        req_ready   = 1'b0;
        cache_upd   = 1'b0;
        cache_alloc = 1'b0;
        attr_err    = 1'b0;
        mb_wr       = 1'b0;
        mb_clr      = 1'b0;
        idle_tick   = 1'b0;
        bus_valid   = 1'b0;
        bop         = BUS_READ;
        bus_addr    = '0;
        bus_data    = '0;
        bus_be      = '0;
        bus_attr    = '0;

        case (ctl_q.state)
            ST_IDLE: begin
                if (!req_valid) begin
                    idle_tick = 1'b1;
                    if (mb_expired) ctl_d.state = ST_FLUSH;
                end else begin
                    case (op)
                        REQ_LOAD: begin
                            if (mb_vld)         ctl_d.state = ST_FLUSH;
                            else if (eff.ci)    ctl_d.state = ST_SINGLE;
                            else if (cache_hit) req_ready   = 1'b1;
                            else ctl_d.state = cache_dirty ? ST_COPYBACK : ST_FILL;
                        end
                        REQ_STORE: begin
                            if (eff.ci) begin
                                if (!mb_vld || mb_match) begin
                                    req_ready = 1'b1;
                                    mb_wr     = 1'b1;
                                    attr_err  = cache_hit;
                                end else begin
                                    ctl_d.state = ST_FLUSH;
                                end
                            end else if (mb_vld) begin
                                ctl_d.state = ST_FLUSH;
                            end else if (eff.wt) begin
                                ctl_d.state = ST_SINGLE;
                            end else if (cache_hit) begin
                                req_ready = 1'b1;
                                cache_upd = 1'b1;
                            end else begin
                                ctl_d.state = cache_dirty ? ST_COPYBACK : ST_FILL;
                            end
                        end
                        REQ_SYNC: begin
                            if (mb_vld) ctl_d.state = ST_FLUSH;
                            else        req_ready   = 1'b1;
                        end
                        default: begin
                            if (mb_vld && mb_attr.grd) ctl_d.state = ST_FLUSH;
                            else                       req_ready   = 1'b1;
                        end
                    endcase
                end
            end
            ST_FLUSH: begin
                bus_valid = 1'b1;
                bop       = BUS_WRITE;
                bus_addr  = {mb_dword, {OFS{1'b0}}};
                bus_data  = mb_data;
                bus_be    = mb_be;
                bus_attr  = mb_attr;
                if (bus_ready) begin
                    mb_clr      = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end
            ST_SINGLE: begin
                bus_valid = 1'b1;
                bop       = is_store ? BUS_WRITE : BUS_READ;
                bus_addr  = req_addr;
                bus_data  = is_store ? req_data : '0;
                bus_be    = req_be;
                bus_attr  = eff;
                if (bus_ready) begin
                    req_ready   = 1'b1;
                    cache_upd   = is_store && cache_hit && !eff.ci;
                    attr_err    = eff.ci && cache_hit;
                    ctl_d.state = ST_IDLE;
                end
            end
            ST_COPYBACK: begin
                bus_valid = 1'b1;
                bop       = BUS_COPYBACK;
                bus_addr  = victim_addr;
                bus_be    = '1;
                bus_attr  = eff;
                if (bus_ready) ctl_d.state = ST_FILL;
            end
            ST_FILL: begin
                bus_valid = 1'b1;
                bop       = BUS_FILL;
                bus_addr  = {req_addr[AW-1:LOFS], {LOFS{1'b0}}};
                bus_be    = '1;
                bus_attr  = eff;
                if (bus_ready) begin
                    req_ready   = 1'b1;
                    cache_alloc = 1'b1;
                    cache_upd   = is_store;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_op = bop;
endmodule

// File: rtl/cattr_checker.sv
module cattr_checker #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [1:0]      req_op,
    input logic [3:0]      req_wimg,
    input logic            req_xlate,
    input logic            cache_hit,
    input logic            cache_upd,
    input logic            cache_alloc,
    input logic            attr_err,
    input logic            bus_valid,
    input logic            bus_ready,
    input logic [1:0]      bus_op,
    input logic [AW-1:0]   bus_addr,
    input logic [DW/8-1:0] bus_be
);
    logic [3:0] eff;
    logic       done, st;
    assign eff  = req_xlate ? req_wimg : 4'b0011;
    assign done = req_valid && req_ready;
    assign st   = (req_op == 2'd1);

    a_r12_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_op) && $stable(bus_be));

    a_r12_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> req_valid);

    a_r2_wt_store_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        done && st && eff[3] && !eff[2] |-> bus_valid && bus_ready && bus_op == 2'd1);

    a_r3_wb_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done && st && !eff[3] && !eff[2] && cache_hit |-> !bus_valid && cache_upd);

    a_r4_alloc_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
        cache_alloc |-> bus_valid && bus_ready && bus_op == 2'd2);

    a_r5_wt_miss_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        done && st && eff[3] && !eff[2] && !cache_hit |-> !cache_alloc && !cache_upd);

    a_r6_ci_no_cache: assert property (@(posedge clk) disable iff (!rst_n)
        done && eff[2] |-> !cache_upd && !cache_alloc);

    a_r7_err_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        attr_err |-> done && cache_hit && eff[2]);
endmodule

bind cache_attr_ctrl cattr_checker #(.AW(AW), .DW(DW)) i_cattr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_wimg    (req_wimg),
    .req_xlate   (req_xlate),
    .cache_hit   (cache_hit),
    .cache_upd   (cache_upd),
    .cache_alloc (cache_alloc),
    .attr_err    (attr_err),
    .bus_valid   (bus_valid),
    .bus_ready   (bus_ready),
    .bus_op      (bus_op),
    .bus_addr    (bus_addr),
    .bus_be      (bus_be)
);

// File: tb/test_cache_attr_ctrl.sv
module test_cache_attr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 32;
    localparam int DW  = 64;
    localparam int TMO = 16;
    localparam logic [31:0] VICTIM = 32'h0000_0800;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0, req_ready;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [7:0]    req_be = '0;
    logic [3:0]    req_wimg = '0;
    logic          req_xlate = 1'b1, cache_hit = 1'b0, cache_dirty = 1'b0;
    logic [AW-1:0] victim_addr = VICTIM;
    logic          cache_upd, cache_alloc, attr_err, bus_valid;
    logic          bus_ready = 1'b0;
    logic [1:0]    bus_op;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic [7:0]    bus_be;
    logic [3:0]    bus_attr;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_attr_ctrl #(.AW(AW), .DW(DW), .LINE_BYTES(32), .TMO(TMO)) i_cache_attr_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
        .req_wimg(req_wimg), .req_xlate(req_xlate), .cache_hit(cache_hit),
        .cache_dirty(cache_dirty), .victim_addr(victim_addr), .cache_upd(cache_upd),
        .cache_alloc(cache_alloc), .attr_err(attr_err), .bus_valid(bus_valid),
        .bus_ready(bus_ready), .bus_op(bus_op), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_be(bus_be), .bus_attr(bus_attr)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic [3:0]  wimg;
        logic        xl;
        logic        hit;
        logic        dirty;
        logic [2:0]  nbus;
        logic [1:0]  op0;
        logic [1:0]  opl;
        logic [31:0] laddr;
        logic [3:0]  lattr;
        logic        upd;
        logic        alloc;
        logic        err;
        logic [3:0]  rq;
    } vec_t;

    // op: 0 load 1 store; bus op: 0 read 1 write 2 fill 3 copy-back
    localparam vec_t TBL [10] = '{
        '{2'd0, 32'h100, 4'b0000, 1'b1, 1'b1, 1'b0, 3'd0, 2'd0, 2'd0, 32'h0,   4'b0000, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 load hit
        '{2'd1, 32'h108, 4'b0000, 1'b1, 1'b1, 1'b0, 3'd0, 2'd0, 2'd0, 32'h0,   4'b0000, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 store hit
        '{2'd1, 32'h110, 4'b1000, 1'b1, 1'b1, 1'b0, 3'd1, 2'd1, 2'd1, 32'h110, 4'b1000, 1'b1, 1'b0, 1'b0, 4'd2}, // R2
        '{2'd1, 32'h118, 4'b1000, 1'b1, 1'b0, 1'b0, 3'd1, 2'd1, 2'd1, 32'h118, 4'b1000, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
        '{2'd0, 32'h124, 4'b0010, 1'b1, 1'b0, 1'b0, 3'd1, 2'd2, 2'd2, 32'h120, 4'b0010, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 clean
        '{2'd1, 32'h148, 4'b0000, 1'b1, 1'b0, 1'b1, 3'd2, 2'd3, 2'd2, 32'h140, 4'b0000, 1'b1, 1'b1, 1'b0, 4'd4}, // R4 dirty
        '{2'd0, 32'h204, 4'b0100, 1'b1, 1'b0, 1'b0, 3'd1, 2'd0, 2'd0, 32'h204, 4'b0100, 1'b0, 1'b0, 1'b0, 4'd6}, // R6
        '{2'd0, 32'h20C, 4'b0101, 1'b1, 1'b1, 1'b0, 3'd1, 2'd0, 2'd0, 32'h20C, 4'b0101, 1'b0, 1'b0, 1'b1, 4'd7}, // R7
        '{2'd1, 32'h300, 4'b1100, 1'b0, 1'b1, 1'b0, 3'd0, 2'd0, 2'd0, 32'h0,   4'b0000, 1'b1, 1'b0, 1'b0, 4'd1}, // R1
        '{2'd0, 32'h31C, 4'b0100, 1'b0, 1'b0, 1'b0, 3'd1, 2'd2, 2'd2, 32'h300, 4'b0011, 1'b0, 1'b1, 1'b0, 4'd1}  // R1
    };

    int errors = 0, checks = 0;
    int nbus, nsteps, rdy_delay = 0, wait_cnt = 0;
    logic [1:0]  lop   [8];
    logic [31:0] laddr [8];
    logic [7:0]  lbe   [8];
    logic [63:0] ldat  [8];
    logic [3:0]  lattr [8];
    bit s_upd, s_alloc, s_err, s_done, hold_bad, prev_pend;
    logic [31:0] prev_addr;

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        bus_ready = bus_valid && (wait_cnt >= rdy_delay);
        #1;
        nsteps++;
        if (prev_pend && bus_valid && bus_addr != prev_addr) hold_bad = 1'b1;
        if (bus_valid && bus_ready) begin
            if (nbus < 8) begin
                lop[nbus] = bus_op; laddr[nbus] = bus_addr; lbe[nbus] = bus_be;
                ldat[nbus] = bus_data; lattr[nbus] = bus_attr;
            end
            nbus++; wait_cnt = 0; prev_pend = 1'b0;
        end else if (bus_valid) begin
            wait_cnt++; prev_pend = 1'b1; prev_addr = bus_addr;
        end else begin
            prev_pend = 1'b0;
        end
        s_upd   |= cache_upd;
        s_alloc |= cache_alloc;
        s_err   |= attr_err;
        if (req_valid && req_ready) s_done = 1'b1;
    endtask

    task automatic clear_log();
        nbus = 0; nsteps = 0; s_upd = 0; s_alloc = 0; s_err = 0; s_done = 0; hold_bad = 0;
    endtask

    task automatic do_req(input logic [1:0] op, input logic [31:0] addr, input logic [63:0] data,
                          input logic [7:0] be, input logic [3:0] wimg, input logic xl,
                          input logic hit, input logic dirty);
        clear_log();
        req_op = op; req_addr = addr; req_data = data; req_be = be; req_wimg = wimg;
        req_xlate = xl; cache_hit = hit; cache_dirty = dirty; req_valid = 1'b1;
        while (!s_done && nsteps < 60) step();
        if (!s_done) chk("R12", "request never completed", 0, 1);
        @(posedge clk);
        #1;
        req_valid = 1'b0; cache_hit = 1'b0; cache_dirty = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R12", "bus_valid in reset", bus_valid, 0);
        chk("R12", "req_ready in reset", req_ready, 0);
        chk("R12", "cache cmds in reset", {cache_upd, cache_alloc, attr_err}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        clear_log();
        step();
        chk("R12", "bus_valid after reset", bus_valid, 0);

        foreach (TBL[i]) begin
            vec_t v = TBL[i];
            string rq = $sformatf("R%0d", v.rq);
            do_req(v.op, v.addr, 64'h1122_3344_5566_7788, 8'hFF, v.wimg, v.xl, v.hit, v.dirty);
            chk(rq, $sformatf("row %0d bus count", i), nbus, v.nbus);
            if (v.nbus != 0) begin
                chk(rq, $sformatf("row %0d first op", i), lop[0], v.op0);
                chk(rq, $sformatf("row %0d last op", i), lop[v.nbus-1], v.opl);
                chk(rq, $sformatf("row %0d last addr", i), laddr[v.nbus-1], v.laddr);
                chk(rq, $sformatf("row %0d attr", i), lattr[v.nbus-1], v.lattr);
                if (v.op0 == 2'd3) chk(rq, "copy-back addr", laddr[0], VICTIM);
            end
            chk(rq, $sformatf("row %0d cache_upd", i), s_upd, v.upd);
            chk(rq, $sformatf("row %0d cache_alloc", i), s_alloc, v.alloc);
            chk(rq, $sformatf("row %0d attr_err", i), s_err, v.err);
        end

        // R8: two inhibited stores merge, R10: full barrier drains them
        do_req(2'd1, 32'h400, 64'hAAAA_AAAA_1111_2222, 8'h0F, 4'b0100, 1, 0, 0);
        chk("R8", "first merge store bus", nbus, 0);
        do_req(2'd1, 32'h404, 64'h3333_4444_BBBB_BBBB, 8'hF0, 4'b0100, 1, 0, 0);
        chk("R8", "second merge store bus", nbus, 0);
        do_req(2'd2, 32'h0, 64'h0, 8'h00, 4'b0000, 1, 0, 0);
        chk("R10", "sync drain count", nbus, 1);
        chk("R8", "merged addr", laddr[0], 32'h400);
        chk("R8", "merged be", lbe[0], 8'hFF);
        chk("R8", "merged data", ldat[0], 64'h3333_4444_1111_2222);
        chk("R8", "merged attr", lattr[0], 4'b0100);

        // R10: ordering barrier ignored for unguarded, R11: load drains
        do_req(2'd1, 32'h500, 64'h55, 8'h01, 4'b0100, 1, 0, 0);
        do_req(2'd3, 32'h0, 64'h0, 8'h00, 4'b0000, 1, 0, 0);
        chk("R10", "order barrier unguarded bus", nbus, 0);
        do_req(2'd0, 32'h508, 64'h0, 8'hFF, 4'b0100, 1, 0, 0);
        chk("R11", "load drain count", nbus, 2);
        chk("R11", "drain before load op", lop[0], 2'd1);
        chk("R11", "drain addr", laddr[0], 32'h500);
        chk("R11", "drain be", lbe[0], 8'h01);
        chk("R11", "load after drain", lop[1], 2'd0);

        // R10: ordering barrier drains guarded
        do_req(2'd1, 32'h600, 64'h66, 8'hFF, 4'b0101, 1, 0, 0);
        do_req(2'd3, 32'h0, 64'h0, 8'h00, 4'b0000, 1, 0, 0);
        chk("R10", "order barrier guarded count", nbus, 1);
        chk("R10", "order barrier guarded addr", laddr[0], 32'h600);

        // R11: non-matching doubleword drains first
        do_req(2'd1, 32'h700, 64'h77, 8'hFF, 4'b0100, 1, 0, 0);
        do_req(2'd1, 32'h708, 64'h78, 8'hFF, 4'b0100, 1, 0, 0);
        chk("R11", "mismatch drain count", nbus, 1);
        chk("R11", "mismatch drain addr", laddr[0], 32'h700);
        do_req(2'd2, 32'h0, 64'h0, 8'h00, 4'b0000, 1, 0, 0);
        chk("R11", "second buffer addr", laddr[0], 32'h708);

        // R8: differing attribute in same doubleword does not merge
        do_req(2'd1, 32'h780, 64'h1, 8'h01, 4'b0100, 1, 0, 0);
        do_req(2'd1, 32'h781, 64'h200, 8'h02, 4'b0101, 1, 0, 0);
        chk("R8", "attr mismatch drain", nbus, 1);
        chk("R8", "attr mismatch be", lbe[0], 8'h01);
        do_req(2'd3, 32'h0, 64'h0, 8'h00, 4'b0000, 1, 0, 0);
        chk("R10", "guarded buffer drained", nbus, 1);

        // R11: timeout drain
        do_req(2'd1, 32'h900, 64'h99, 8'hFF, 4'b0100, 1, 0, 0);
        clear_log();
        while (nbus == 0 && nsteps < 60) step();
        chk("R11", "timeout drain count", nbus, 1);
        chk("R11", "timeout not early", (nsteps >= TMO - 1), 1);
        chk("R11", "timeout not late", (nsteps <= TMO + 3), 1);
        chk("R11", "timeout addr", laddr[0], 32'h900);

        // R9: write-through stores never merge
        do_req(2'd1, 32'hA00, 64'h0A, 8'h0F, 4'b1000, 1, 0, 0);
        chk("R9", "first wt store writes", nbus, 1);
        chk("R9", "first wt be", lbe[0], 8'h0F);
        do_req(2'd1, 32'hA04, 64'h0B, 8'hF0, 4'b1000, 1, 0, 0);
        chk("R9", "second wt store writes", nbus, 1);
        chk("R9", "second wt addr", laddr[0], 32'hA04);

        // R12: stalled bus holds request and requester
        rdy_delay = 3;
        do_req(2'd1, 32'hB00, 64'hBB, 8'hFF, 4'b1000, 1, 1, 0);
        rdy_delay = 0;
        chk("R12", "stall bus count", nbus, 1);
        chk("R12", "stall held cycles", (nsteps >= 5), 1);
        chk("R12", "address held under stall", hold_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule